// File: doc/BRIEF.md
# SD Card Command Sequencer

This block issues one command on the SD card CMD line at a time, under control of a small 32-bit register bus. Software first loads the argument word, then writes the command word. That word carries a 6-bit index, the kind of response expected, a wait-for-busy flag, two data-direction flags, and a start bit that hardware clears on its own. The block builds the 48-bit command token with its CRC7 and shifts it out one bit per SD clock. It then releases the line and, unless the command expects no response, waits a programmable number of SD clocks for the card's start bit. It collects a short 48-bit or a long 136-bit response. When asked, it then holds the command open while DAT0 shows the card busy.

Completion is seen by polling the command word until its start bit drops. A command-failed bit in the same word marks a timeout. Response errors and timeouts are also recorded in a separate status word, and software clears its flags by writing ones. Response payloads land in four response words. The SD clock is a free-running enable pulse derived from the system clock by a fixed divider.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, every register reads zero, `cmd_oe` is 0 and `cmd_out` is 1. Byte offsets: 0x00 command, 0x04 argument, 0x08 timeout limit, 0x10/0x14/0x18/0x1C response words 0..3, 0x20 status. Whenever `cmd_oe` is 0, `cmd_out` is 1.
- R2: Writing the command word with bit 15 set starts a command. Bit 15 reads 1 while the command runs and 0 once it finishes. Starting a command clears bit 14. Bits 11:9 and 7:0 read back as written.
- R3: The token leaves MSB first, one bit per `sd_clk_en` pulse, with `cmd_oe` high for exactly 48 bits. It consists of a 0, a 1, index bits 5:0, then argument bits 31:0, then a CRC7 (x^7+x^3+1, zero seed) over those first 40 bits, then a 1. `cmd_oe` is never high while no command runs.
- R4: With command bit 10 (no response) set, the command finishes after the token. Status stays 0, bit 14 stays 0, and the response words are left unchanged.
- R5: For a short response (bits 10 and 9 clear), 48 bits are taken starting at the first 0 seen on `cmd_in`, and response bits 39:8 go to response word 0. If bits 7:1 differ from the CRC7 of bits 47:8, status bit 4 is set; bit 14 is not set by this.
- R6: With bit 9 set (long response), 136 bits are taken. The last 128 are stored with bits 127:96 in word 3, down to bits 31:0 in word 0. No CRC7 check is made.
- R7: If no 0 is seen on `cmd_in` within T SD clocks after release, where T is the timeout register, the command ends and sets status bit 6 and command bit 14.
- R8: With bit 11 set, bit 15 stays 1 after the response until `dat0_in` is seen high. If `dat0_in` stays low for T SD clocks, status bit 6 and command bit 14 are set.
- R9: Writing the status word clears each flag whose data bit is 1 and leaves the others; writing 0xFFFF clears all.
- R10: Writes to the command word while a command runs are ignored: no new token, and the stored index is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, one cycle after the address |
| sd_clk_en | output | 1 | One-cycle SD clock pulse, every CLK_DIV cycles |
| cmd_out | output | 1 | CMD line value driven toward the card |
| cmd_oe | output | 1 | CMD line output enable |
| cmd_in | input | 1 | CMD line value from the card |
| dat0_in | input | 1 | DAT0 line from the card, low while busy |

## Verification
The hardest states to reach are those the card alone controls: a response whose start bit arrives a few SD clocks late, a response with a corrupted CRC7, silence on CMD, and DAT0 held low after the response. The bench plays the card. Its process runs on the SD clock pulse, captures every driven token bit, and drives a prepared response bit queue after a chosen idle gap. It can also hold DAT0 low for a set number of SD clocks or forever. The busy case is judged by sampling the command word's run bit at the very moment DAT0 is released. The ignored-write case is judged by issuing a second start in the middle of a token and counting the bits that leave.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAITR, ST_RECV, ST_CHECK, ST_BUSY, ST_FIN
  } seq_state_t;

  localparam int TOKEN_BITS = 48;
  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;

  // command word bit positions
  localparam int CB_LONG = 9;
  localparam int CB_NONE = 10;
  localparam int CB_BUSY = 11;
  localparam int CB_RUN  = 15;
  localparam logic [11:0] CB_KEEP = 12'hEFF;

  // status bit positions
  localparam int HS_CRC = 4;
  localparam int HS_TMO = 6;

  // word offsets
  localparam int RA_CMD  = 0;
  localparam int RA_ARG  = 1;
  localparam int RA_TMO  = 2;
  localparam int RA_RSP0 = 4;
  localparam int RA_RSP1 = 5;
  localparam int RA_RSP2 = 6;
  localparam int RA_RSP3 = 7;
  localparam int RA_STAT = 8;

  function automatic logic [6:0] crc7_40(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_tick.sv
module sdcmd_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sdcmd_token.sv
module sdcmd_token import sdcmd_pkg::*; (
  input  logic [5:0]            index,
  input  logic [31:0]           arg,
  output logic [TOKEN_BITS-1:0] token
);
  logic [39:0] head;
  assign head  = {2'b01, index, arg};
  assign token = {head, crc7_40(head), 1'b1};
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq import sdcmd_pkg::*; #(
  parameter int TMO_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  start,
  input  logic [TOKEN_BITS-1:0] token,
  input  logic                  rsp_none,
  input  logic                  rsp_long,
  input  logic                  busy_wait,
  input  logic [TMO_W-1:0]      tmo_limit,
  input  logic                  cmd_in,
  input  logic                  dat0_in,
  output logic                  cmd_out,
  output logic                  cmd_oe,
  output logic                  fin,
  output logic                  crc_err,
  output logic                  tmo_err,
  output logic                  rsp_we,
  output logic                  rsp_long_o,
  output logic [127:0]          rsp_bits
);
  seq_state_t            state;
  logic [TOKEN_BITS-1:0] tx_sh;
  logic [127:0]          rx_sh;
  logic [7:0]            bitcnt;
  logic [TMO_W-1:0]      tcnt;
  logic                  none_q, long_q, busy_q;
  logic [7:0]            rx_total;
  logic                  tmo_hit;

  assign rx_total = long_q ? 8'(LONG_BITS) : 8'(SHORT_BITS);
  assign tmo_hit  = (tcnt + TMO_W'(1)) >= tmo_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bitcnt  <= '0;
      tcnt    <= '0;
      none_q  <= 1'b0;
      long_q  <= 1'b0;
      busy_q  <= 1'b0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
      crc_err <= 1'b0;
      tmo_err <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          tx_sh   <= token;
          rx_sh   <= '0;
          bitcnt  <= '0;
          tcnt    <= '0;
          none_q  <= rsp_none;
          long_q  <= rsp_long & ~rsp_none;
          busy_q  <= busy_wait;
          crc_err <= 1'b0;
          tmo_err <= 1'b0;
          state   <= ST_SEND;
        end
        ST_SEND: if (tick) begin
          if (bitcnt == 8'(TOKEN_BITS)) begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            state   <= none_q ? ST_FIN : ST_WAITR;
          end else begin
            cmd_oe  <= 1'b1;
            cmd_out <= tx_sh[TOKEN_BITS-1];
            tx_sh   <= {tx_sh[TOKEN_BITS-2:0], 1'b0};
            bitcnt  <= bitcnt + 1'b1;
          end
        end
        ST_WAITR: if (tick) begin
          if (!cmd_in) begin
            rx_sh  <= '0;
            bitcnt <= 8'd1;
            state  <= ST_RECV;
          end else if (tmo_hit) begin
            tmo_err <= 1'b1;
            state   <= ST_FIN;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RECV: if (tick) begin
          rx_sh  <= {rx_sh[126:0], cmd_in};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == rx_total - 8'd1) state <= ST_CHECK;
        end
        ST_CHECK: begin
          crc_err <= ~long_q && (crc7_40(rx_sh[47:8]) != rx_sh[7:1]);
          tcnt    <= '0;
          state   <= busy_q ? ST_BUSY : ST_FIN;
        end
        ST_BUSY: if (tick) begin
          if (dat0_in) begin
            state <= ST_FIN;
          end else if (tmo_hit) begin
            tmo_err <= 1'b1;
            state   <= ST_FIN;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fin        = (state == ST_FIN);
  assign rsp_we     = (state == ST_CHECK);
  assign rsp_long_o = long_q;
  assign rsp_bits   = long_q ? rx_sh : {96'd0, rx_sh[39:8]};
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine import sdcmd_pkg::*; #(
  parameter int CLK_DIV = 4,
  parameter int TMO_W   = 24,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sd_clk_en,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  input  logic              dat0_in
);
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0]     wsel;
  logic                  aligned;
  logic                  wr_cmd, wr_arg, wr_tmo, wr_stat, start;
  logic                  run_q, fail_q;
  logic [11:0]           cmd_f;
  logic [31:0]           arg_q;
  logic [TMO_W-1:0]      tmo_q;
  logic [15:0]           stat_q, stat_set, stat_clr;
  logic [31:0]           rsp_w [4];
  logic [TOKEN_BITS-1:0] token;
  logic                  tick, seq_fin, seq_crc, seq_tmo, rsp_we, rsp_long;
  logic [127:0]          rsp_bits;

  assign wsel    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_cmd  = bus_wr && aligned && (wsel == WSEL_W'(RA_CMD)) && !run_q;
  assign wr_arg  = bus_wr && aligned && (wsel == WSEL_W'(RA_ARG));
  assign wr_tmo  = bus_wr && aligned && (wsel == WSEL_W'(RA_TMO));
  assign wr_stat = bus_wr && aligned && (wsel == WSEL_W'(RA_STAT));
  assign start   = wr_cmd && bus_wdata[CB_RUN];

  sdcmd_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  sdcmd_token u_token (.index(bus_wdata[5:0]), .arg(arg_q), .token(token));

  sdcmd_seq #(.TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .token(token),
    .rsp_none(bus_wdata[CB_NONE]), .rsp_long(bus_wdata[CB_LONG]),
    .busy_wait(bus_wdata[CB_BUSY]), .tmo_limit(tmo_q),
    .cmd_in(cmd_in), .dat0_in(dat0_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .fin(seq_fin),
    .crc_err(seq_crc), .tmo_err(seq_tmo), .rsp_we(rsp_we),
    .rsp_long_o(rsp_long), .rsp_bits(rsp_bits)
  );

  assign sd_clk_en = tick;

  always_comb begin
    stat_set = '0;
    if (seq_fin) begin
      stat_set[HS_CRC] = seq_crc;
      stat_set[HS_TMO] = seq_tmo;
    end
    stat_clr = wr_stat ? bus_wdata[15:0] : 16'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      fail_q <= 1'b0;
      cmd_f  <= '0;
      arg_q  <= '0;
      tmo_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_cmd) cmd_f <= bus_wdata[11:0] & CB_KEEP;
      if (start) begin
        run_q  <= 1'b1;
        fail_q <= 1'b0;
      end else if (seq_fin) begin
        run_q  <= 1'b0;
        fail_q <= seq_tmo;
      end
      if (wr_arg) arg_q <= bus_wdata;
      if (wr_tmo) tmo_q <= bus_wdata[TMO_W-1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  // response words: word 0 for any response, words 1..3 only for long ones
  for (genvar g = 0; g < 4; g++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (rst) rsp_w[g] <= '0;
      else if (rsp_we && (g == 0 || rsp_long)) rsp_w[g] <= rsp_bits[32*g +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (!aligned) begin
      bus_rdata <= '0;
    end else begin
      case (int'(wsel))
        RA_CMD:  bus_rdata <= {16'd0, run_q, fail_q, 2'b00, cmd_f};
        RA_ARG:  bus_rdata <= arg_q;
        RA_TMO:  bus_rdata <= 32'(tmo_q);
        RA_RSP0: bus_rdata <= rsp_w[0];
        RA_RSP1: bus_rdata <= rsp_w[1];
        RA_RSP2: bus_rdata <= rsp_w[2];
        RA_RSP3: bus_rdata <= rsp_w[3];
        RA_STAT: bus_rdata <= {16'd0, stat_q};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sd_clk_en,
  input logic              cmd_out,
  input logic              cmd_oe,
  input logic              run_q,
  input logic              fail_q,
  input logic [11:0]       cmd_f,
  input logic [15:0]       stat_q,
  input logic              seq_fin,
  input logic              seq_crc,
  input logic              seq_tmo
);
  logic [7:0] oe_cnt;
  logic       stat_wr;

  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(32'h20));

  always_ff @(posedge clk) begin
    if (rst || !run_q) oe_cnt <= '0;
    else if (sd_clk_en && cmd_oe) oe_cnt <= oe_cnt + 1'b1;
  end

  AST_LINE_HIGH_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe |-> cmd_out);                                              // R1
  AST_RUN_DROPS_AFTER_FIN: assert property (@(posedge clk) disable iff (rst)
    seq_fin |=> !run_q);                                               // R2
  AST_OE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    cmd_oe |-> run_q);                                                 // R3
  AST_TOKEN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    oe_cnt <= 8'd48);                                                  // R3
  AST_CRC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    seq_fin && seq_crc |=> stat_q[4]);                                 // R5
  AST_TMO_REPORTED: assert property (@(posedge clk) disable iff (rst)
    seq_fin && seq_tmo |=> fail_q && stat_q[6]);                       // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stat_wr && bus_wdata[4] && !seq_fin |=> !stat_q[4]);               // R9
  AST_RUNNING_IGNORES_CMD: assert property (@(posedge clk) disable iff (rst)
    run_q && !seq_fin |=> run_q && $stable(cmd_f));                    // R10
endmodule

bind sdcmd_engine sdcmd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sd_clk_en(sd_clk_en), .cmd_out(cmd_out),
  .cmd_oe(cmd_oe), .run_q(run_q), .fail_q(fail_q), .cmd_f(cmd_f),
  .stat_q(stat_q), .seq_fin(seq_fin), .seq_crc(seq_crc), .seq_tmo(seq_tmo)
);

// File: tb/sdcmd_engine_test.sv
`timescale 1ns/1ps
module sdcmd_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sd_clk_en, cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;
  logic        dat0 = 1'b1;

  int total = 0, bad = 0;
  bit finished = 0;

  // card model state
  bit cap_q[$];
  bit rsp_q[$];
  bit armed = 0, rsp_done = 0, pending = 0;
  int dly = 0, busy_ticks = -1;
  bit run_at_rise = 0, dat0_rose = 0;
  int oe_err = 0, line_err = 0;

  always #2.5 clk = ~clk;

  sdcmd_engine uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_clk_en(sd_clk_en),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0)
  );

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_token(input logic [5:0] i, input logic [31:0] a);
    logic [39:0] h = {2'b01, i, a};
    return {h, ref_crc(h), 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // the card, acting on every SD clock pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_oe && !pending) oe_err++;
      if (!cmd_oe && !cmd_out) line_err++;
      if (sd_clk_en) begin
        if (cmd_oe) cap_q.push_back(cmd_out);
        else if (cap_q.size() == 48 && armed) begin
          if (dly > 0) begin
            cmd_in = 1'b1;
            dly--;
          end else begin
            cmd_in = rsp_q.pop_front();
            if (rsp_q.size() == 0) begin
              armed = 0;
              rsp_done = 1;
            end
          end
        end else begin
          cmd_in = 1'b1;
          if (rsp_done && !dat0 && busy_ticks >= 0) begin
            if (busy_ticks == 0) begin
              dat0 = 1'b1;
              dat0_rose = 1;
              run_at_rise = bus_rdata[15];
            end else busy_ticks--;
          end
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    @(negedge clk);
    bus_addr = 8'h00;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 20000; k++) begin
      if (!bus_rdata[15]) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    check(seen, req, 128'(bus_rdata), 128'h0);
    repeat (2) @(negedge clk);
    pending = 0;
  endtask

  // arm the card, load the argument, start the command
  task automatic launch(input logic [5:0] idx, input logic [31:0] arg, input logic [15:0] flags,
                        input bit [135:0] rsp, input int nbits, input int gap, input int busy);
    logic [31:0] v;
    cap_q.delete();
    rsp_q.delete();
    for (int k = nbits - 1; k >= 0; k--) rsp_q.push_back(rsp[k]);
    armed = (nbits > 0);
    rsp_done = 0;
    dly = gap;
    busy_ticks = busy;
    dat0_rose = 0;
    dat0 = (busy == -2) ? 1'b1 : 1'b0;
    if (busy == -2) busy_ticks = -1;
    wr(8'h04, arg);
    pending = 1;
    wr(8'h00, 32'h8000 | 32'(flags) | 32'(idx));
    rd(8'h00, v);
    check(v[15] == 1'b1, "R2 run bit set after start", 128'(v[15]), 128'h1);
  endtask

  function automatic logic [47:0] captured();
    logic [47:0] v = '0;
    for (int k = 0; k < cap_q.size() && k < 48; k++) v = {v[46:0], cap_q[k]};
    return v;
  endfunction

  function automatic bit [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] pay, input bit corrupt);
    logic [39:0] h = {2'b00, idx, pay};
    logic [6:0] c = ref_crc(h) ^ (corrupt ? 7'h01 : 7'h00);
    return 136'({h, c, 1'b1});
  endfunction

  logic [31:0] r;
  logic [127:0] long_data;

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(cmd_oe == 1'b0 && cmd_out == 1'b1, "R1 line idle after reset", 128'({cmd_oe, cmd_out}), 128'h1);
    for (int a = 0; a <= 8; a++) begin
      rd(8'(a * 4), r);
      check(r == 32'h0, "R1 register zero after reset", 128'(r), 128'h0);
    end

    wr(8'h08, 32'd20);

    // R4, R3: no-response command
    launch(6'd0, 32'h0, 16'h0400, 136'h0, 0, 0, -2);
    wait_done("R4 no-response finishes");
    check(cap_q.size() == 48, "R3 token length", 128'(cap_q.size()), 128'd48);
    check(captured() == ref_token(6'd0, 32'h0), "R3 token bits idx0", 128'(captured()), 128'(ref_token(6'd0, 32'h0)));
    rd(8'h20, r);
    check(r == 32'h0, "R4 status clean", 128'(r), 128'h0);
    rd(8'h10, r);
    check(r == 32'h0, "R4 response word untouched", 128'(r), 128'h0);
    rd(8'h00, r);
    check(r == 32'h0400, "R2 command readback", 128'(r), 128'h0400);

    // R5, R3: short response with a good CRC, late start bit
    launch(6'd17, 32'h12345678, 16'h00C0, short_rsp(6'd17, 32'hCAFEF00D, 0), 48, 3, -2);
    wait_done("R5 short response finishes");
    check(captured() == ref_token(6'd17, 32'h12345678), "R3 token bits idx17", 128'(captured()), 128'(ref_token(6'd17, 32'h12345678)));
    rd(8'h10, r);
    check(r == 32'hCAFEF00D, "R5 response word 0", 128'(r), 128'hCAFEF00D);
    rd(8'h20, r);
    check(r == 32'h0, "R5 good CRC no flag", 128'(r), 128'h0);
    rd(8'h00, r);
    check(r == 32'h00D1, "R2 flags and index readback", 128'(r), 128'h00D1);

    // R5: corrupted CRC
    launch(6'd13, 32'h00000001, 16'h0, short_rsp(6'd13, 32'h0BADBEEF, 1), 48, 0, -2);
    wait_done("R5 bad CRC finishes");
    rd(8'h20, r);
    check(r == 32'h10, "R5 CRC flag set", 128'(r), 128'h10);
    rd(8'h00, r);
    check(r[14] == 1'b0, "R5 CRC does not fail command", 128'(r[14]), 128'h0);

    // R7: no response at all
    launch(6'd8, 32'h1AA, 16'h0, 136'h0, 0, 0, -2);
    wait_done("R7 timeout finishes");
    rd(8'h20, r);
    check(r == 32'h50, "R7 timeout flag", 128'(r), 128'h50);
    rd(8'h00, r);
    check(r[15:14] == 2'b01, "R7 failed bit", 128'(r[15:14]), 128'h1);

    // R9: clear-by-one
    wr(8'h20, 32'h10);
    rd(8'h20, r);
    check(r == 32'h40, "R9 partial clear", 128'(r), 128'h40);
    wr(8'h20, 32'hFFFF);
    rd(8'h20, r);
    check(r == 32'h0, "R9 clear all", 128'(r), 128'h0);

    // R6: long response, CRC bits deliberately arbitrary
    long_data = 128'h0123456789ABCDEF_FEDCBA9876543211;
    launch(6'd2, 32'h0, 16'h0200, {8'h3F, long_data}, 136, 2, -2);
    wait_done("R6 long response finishes");
    rd(8'h00, r);
    check(r[14] == 1'b0, "R2 start clears failed bit", 128'(r[14]), 128'h0);
    for (int w = 0; w < 4; w++) begin
      rd(8'(16 + 4 * w), r);
      check(r == long_data[32*w +: 32], "R6 long word", 128'(r), 128'(long_data[32*w +: 32]));
    end
    rd(8'h20, r);
    check(r == 32'h0, "R6 no CRC check", 128'(r), 128'h0);

    // R8: busy released after 8 SD clocks
    launch(6'd7, 32'h0, 16'h0800, short_rsp(6'd7, 32'h00000700, 0), 48, 0, 8);
    wait_done("R8 busy command finishes");
    check(dat0_rose && run_at_rise, "R8 run held while busy", 128'({dat0_rose, run_at_rise}), 128'h3);
    rd(8'h20, r);
    check(r == 32'h0, "R8 busy clean status", 128'(r), 128'h0);

    // R8: busy never released
    launch(6'd12, 32'h0, 16'h0800, short_rsp(6'd12, 32'h0, 0), 48, 0, -1);
    wait_done("R8 busy timeout finishes");
    rd(8'h20, r);
    check(r == 32'h40, "R8 busy timeout flag", 128'(r), 128'h40);
    rd(8'h00, r);
    check(r[14] == 1'b1, "R8 busy timeout fails", 128'(r[14]), 128'h1);
    dat0 = 1'b1;
    wr(8'h20, 32'hFFFF);

    // R10: a second start in mid-token is ignored
    launch(6'd5, 32'hA5A5A5A5, 16'h0400, 136'h0, 0, 0, -2);
    repeat (40) @(negedge clk);
    wr(8'h00, 32'h8409);
    wait_done("R10 first command finishes");
    repeat (300) @(negedge clk);
    check(cap_q.size() == 48, "R10 only one token", 128'(cap_q.size()), 128'd48);
    check(captured() == ref_token(6'd5, 32'hA5A5A5A5), "R10 token unchanged", 128'(captured()), 128'(ref_token(6'd5, 32'hA5A5A5A5)));
    rd(8'h00, r);
    check(r[5:0] == 6'd5, "R10 index unchanged", 128'(r[5:0]), 128'd5);

    check(oe_err == 0, "R3 no drive while idle", 128'(oe_err), 128'h0);
    check(line_err == 0, "R1 released line high", 128'(line_err), 128'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule